// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block collects every interrupt source of a FIFO-equipped UART and turns them into a single interrupt request and an identification byte. The host reads that byte to learn the most urgent cause. The sources are receive-line errors, received data, a receive timeout, transmitter-holding-empty and modem-line changes. The block owns three pieces of state. The first is the four-bit interrupt enable register. The second is the FIFO control register, which holds the FIFO enable, the receive trigger threshold and two self-clearing FIFO reset strobes. The third is the bookkeeping for the two causes that are event-like: the transmitter-empty event and the receive timeout.

The FIFOs, the serializers, the line and modem status registers and the bus decoder are outside the block. The bus decoder turns host accesses into the single-cycle strobes `ier_wr`, `fcr_wr`, `iir_rd` and `thr_wr`. Every pin is a plain control or status signal. Nothing is streamed, so there is no back-pressure. A strobe is acted on in the cycle it is high, and it is never stalled.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to the enable register stores bits 3..0, one per source: bit 0 receive data, bit 1 transmitter empty, bit 2 line error, bit 3 modem change. `ier_q` shows the new value from the next cycle, and its bits 7..4 always read zero.
- R2: A FIFO control write sets the FIFO enable from bit 0 and the trigger select from bits 7..6. The select picks a threshold of 1, 4, 8 or 14 bytes for codes 00, 01, 10 and 11. The receive-data cause is raised when `rx_level` is at or above the threshold in FIFO mode, and at or above 1 in character mode.
- R3: Bit 1 of a FIFO control write pulses `rx_fifo_rst` for exactly one cycle after the write. Bit 2 does the same for `tx_fifo_rst`. Without a write, both strobes stay low.
- R4: The cause code sits in ident bits 2..1: 11 for line error (any `line_err` bit), 10 for receive data or timeout, 01 for transmitter empty, 00 for modem change (any `modem_delta` bit). Only the highest enabled pending cause is reported, in that priority order, and a source whose enable bit is clear has no effect.
- R5: Ident bit 0 is 0 while any enabled cause is pending, and 1 otherwise.
- R6: Ident bits 7..6 read 11 in FIFO mode and 00 in character mode. Bits 5..4 read 0.
- R7: In FIFO mode, with `rx_level` non-zero, `TO_CHARS` character ticks with no push and no pop raise the timeout. A push, a pop, an empty FIFO or character mode clears it.
- R8: Ident bit 3 is 1 only when the reported code is 10 and the timeout is active.
- R9: The transmitter-empty cause becomes pending on a rising edge of `thr_empty`. It also becomes pending when enable bit 1 is written from 0 to 1 while `thr_empty` is high. An `iir_rd` that reports code 01 clears it, and so does a `thr_wr`.
- R10: `irq` is high exactly when a cause is pending and `out2` is high. While `out2` is low, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_q | output | 8 | Enable register readback |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| fifo_en | output | 1 | FIFO mode active |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO reset |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte was read from the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding register empty |
| thr_wr | input | 1 | Host wrote the transmit register |
| line_err | input | 4 | Pending receive-line error flags |
| modem_delta | input | 4 | Pending modem-line change flags |
| out2 | input | 1 | Master interrupt enable |
| iir_rd | input | 1 | Host read of the identification byte |
| ident | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions hold on every cycle for the following properties:
- the enable register write and readback;
- the one-cycle reset strobes;
- the fixed FIFO-mode bits;
- the timeout bit appearing only with the receive code;
- the pending polarity of bit 0;
- the master-enable gating of `irq`.

Three behaviours can only be shown by the bench scenarios:
- The cause priority and the trigger thresholds, which the bench checks against its own model under random enables, levels and error patterns.
- The transmitter-empty event, which needs a sequence of set, read-clear, write-clear and re-arm.
- The timeout, which needs a counted run of character ticks and then a pop.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [1:0] {
    CAUSE_MODEM = 2'b00,
    CAUSE_TX    = 2'b01,
    CAUSE_RX    = 2'b10,
    CAUSE_LINE  = 2'b11
  } cause_e;

  function automatic int trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uirq_fifo_ctrl.sv
module uirq_fifo_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fcr_wr,
  input  logic [7:0] fcr_wdata,
  output logic       fifo_en,
  output logic [1:0] trig_sel,
  output logic       rx_rst,
  output logic       tx_rst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'b00;
      rx_rst   <= 1'b0;
      tx_rst   <= 1'b0;
    end else begin
      rx_rst <= fcr_wr & fcr_wdata[1];
      tx_rst <= fcr_wr & fcr_wdata[2];
      if (fcr_wr) begin
        fifo_en  <= fcr_wdata[0];
        trig_sel <= fcr_wdata[7:6];
      end
    end
  end
endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout #(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  output logic             timed_out
);
  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CHARS - 1);

  logic [CNT_W-1:0] cnt;
  logic             restart;

  assign restart = !fifo_en || (rx_level == '0) || rx_push || rx_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      timed_out <= 1'b0;
    end else if (restart) begin
      cnt       <= '0;
      timed_out <= 1'b0;
    end else if (char_tick && !timed_out) begin
      if (cnt == LAST) timed_out <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uirq_thre_track.sv
module uirq_thre_track (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_empty,
  input  logic arm,
  input  logic clear,
  output logic pend
);
  logic empty_q;
  logic set;

  assign set = (thr_empty & ~empty_q) | arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      pend    <= 1'b0;
    end else begin
      empty_q <= thr_empty;
      pend    <= (pend | set) & ~clear;
    end
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uart_irq_pkg::*;
(
  input  logic       line_req,
  input  logic       rx_req,
  input  logic       to_req,
  input  logic       tx_req,
  input  logic       ms_req,
  input  logic       fifo_en,
  output cause_e     code,
  output logic       pending,
  output logic [7:0] ident
);
  logic to_bit;

  always_comb begin
    pending = 1'b1;
    to_bit  = 1'b0;
    if (line_req) begin
      code = CAUSE_LINE;
    end else if (rx_req || to_req) begin
      code   = CAUSE_RX;
      to_bit = to_req;
    end else if (tx_req) begin
      code = CAUSE_TX;
    end else begin
      code    = CAUSE_MODEM;
      pending = ms_req;
    end
  end

  assign ident = {{2{fifo_en}}, 2'b00, to_bit, code, ~pending};
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [7:0]       ier_q,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  output logic             fifo_en,
  output logic             rx_fifo_rst,
  output logic             tx_fifo_rst,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic [3:0]       line_err,
  input  logic [3:0]       modem_delta,
  input  logic             out2,
  input  logic             iir_rd,
  output logic [7:0]       ident,
  output logic             irq
);
  logic [3:0] en_q;
  logic [1:0] trig_sel;
  logic       timed_out;
  logic       thre_pend;
  logic       pending;
  cause_e     code;
  logic       rx_at_trig;
  int         thresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 4'h0;
    else if (ier_wr) en_q <= ier_wdata[3:0];
  end
  assign ier_q = {4'h0, en_q};

  uirq_fifo_ctrl u_fctl (
    .clk, .rst_n, .fcr_wr, .fcr_wdata,
    .fifo_en, .trig_sel, .rx_rst(rx_fifo_rst), .tx_rst(tx_fifo_rst)
  );

  uirq_rx_timeout #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_to (
    .clk, .rst_n, .fifo_en, .rx_level, .rx_push, .rx_pop, .char_tick,
    .timed_out
  );

  assign thresh     = fifo_en ? trig_bytes(trig_sel) : 1;
  assign rx_at_trig = int'(rx_level) >= thresh;

  uirq_thre_track u_thre (
    .clk, .rst_n, .thr_empty,
    .arm(ier_wr & ier_wdata[1] & ~en_q[1] & thr_empty),
    .clear(thr_wr | (iir_rd & pending & (code == CAUSE_TX))),
    .pend(thre_pend)
  );

  uirq_prio u_prio (
    .line_req(en_q[2] & (|line_err)),
    .rx_req(en_q[0] & rx_at_trig),
    .to_req(en_q[0] & timed_out),
    .tx_req(en_q[1] & thre_pend),
    .ms_req(en_q[3] & (|modem_delta)),
    .fifo_en, .code, .pending, .ident
  );

  assign irq = pending & out2;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic [7:0] ier_q,
  input logic       fcr_wr,
  input logic [7:0] fcr_wdata,
  input logic       fifo_en,
  input logic       rx_fifo_rst,
  input logic       tx_fifo_rst,
  input logic [7:0] ident,
  input logic       irq,
  input logic       out2
);
  // R1
  ier_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == {4'h0, $past(ier_wdata[3:0])}));
  // R3
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fifo_rst || tx_fifo_rst) && !fcr_wr |=> !rx_fifo_rst && !tx_fifo_rst);
  // R3
  rx_strobe_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_wr && fcr_wdata[1] |=> rx_fifo_rst);
  // R6
  mode_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident[7:4] == {fifo_en, fifo_en, 2'b00});
  // R8
  to_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3] |-> ident[2:1] == 2'b10);
  // R5
  pend_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !ident[0]);
  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out2 |-> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ier_wr = 0, fcr_wr = 0, rx_push = 0, rx_pop = 0, char_tick = 0;
  logic       thr_empty = 0, thr_wr = 0, out2 = 0, iir_rd = 0;
  logic [7:0] ier_wdata = 0, fcr_wdata = 0;
  logic [4:0] rx_level = 0;
  logic [3:0] line_err = 0, modem_delta = 0;
  logic [7:0] ier_q, ident;
  logic       fifo_en, rx_fifo_rst, tx_fifo_rst, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ier(input logic [7:0] v);
    @(negedge clk); ier_wr = 1; ier_wdata = v;
    @(negedge clk); ier_wr = 0;
  endtask

  task automatic wr_fcr(input logic [7:0] v);
    @(negedge clk); fcr_wr = 1; fcr_wdata = v;
    @(negedge clk); fcr_wr = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); char_tick = 1;
    @(negedge clk); char_tick = 0;
  endtask

  function automatic logic [7:0] exp_ident(input logic [3:0] en, input int lvl,
      input bit fen, input logic [1:0] ts, input logic [3:0] le,
      input logic [3:0] md, input bit thre, input bit to);
    int thr;
    logic [7:0] top;
    thr = !fen ? 1 : (ts == 0 ? 1 : ts == 1 ? 4 : ts == 2 ? 8 : 14);
    top = {fen, fen, 6'b0};
    if (en[2] && |le)                  return top | 8'h06;
    if (en[0] && (lvl >= thr || to))   return top | 8'h04 | (to ? 8'h08 : 8'h00);
    if (en[1] && thre)                 return top | 8'h02;
    if (en[3] && |md)                  return top;
    return top | 8'h01;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check(ident == 8'h01, "R5 reset ident", ident, 8'h01);
    check(ier_q == 8'h00, "R1 reset ier", ier_q, 0);
    check(irq == 0, "R10 reset irq", irq, 0);

    // R1: upper bits dropped
    wr_ier(8'hFA);
    check(ier_q == 8'h0A, "R1 ier mask", ier_q, 8'h0A);

    // R3: reset strobes one cycle
    wr_fcr(8'h07);
    check(rx_fifo_rst && tx_fifo_rst, "R3 strobe high", {rx_fifo_rst, tx_fifo_rst}, 3);
    check(fifo_en == 1, "R2 fifo enable", fifo_en, 1);
    @(negedge clk);
    check(!rx_fifo_rst && !tx_fifo_rst, "R3 strobe self-clear", {rx_fifo_rst, tx_fifo_rst}, 0);
    wr_fcr(8'h02);
    check(rx_fifo_rst && !tx_fifo_rst, "R3 rx only", {rx_fifo_rst, tx_fifo_rst}, 2);

    // R2: trigger threshold 4 in FIFO mode, then character mode
    wr_ier(8'h01);
    wr_fcr(8'h41);
    rx_level = 3; #1;
    check(ident == 8'hC1, "R2 below trigger", ident, 8'hC1);
    rx_level = 4; #1;
    check(ident == 8'hC4, "R2 at trigger", ident, 8'hC4);
    wr_fcr(8'h40);
    rx_level = 1; #1;
    check(ident == 8'h04, "R6 R2 char mode", ident, 8'h04);
    rx_level = 0;

    // R7 R8: timeout with trigger 14 and level 3
    wr_fcr(8'hC1);
    @(negedge clk); rx_level = 3;
    repeat (3) pulse_tick();
    check(ident == 8'hC1, "R7 before timeout", ident, 8'hC1);
    pulse_tick();
    check(ident == 8'hCC, "R7 R8 timeout", ident, 8'hCC);
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    check(ident == 8'hC1, "R7 pop clears", ident, 8'hC1);
    rx_level = 0;
    wr_fcr(8'h00);

    // R9: transmitter-empty event
    wr_ier(8'h02);
    @(negedge clk); thr_empty = 1;
    @(negedge clk);
    check(ident == 8'h02, "R9 rising edge", ident, 8'h02);
    iir_rd = 1;
    @(negedge clk); iir_rd = 0;
    check(ident == 8'h01, "R9 read clears", ident, 8'h01);
    thr_empty = 0;
    @(negedge clk); thr_empty = 1;
    @(negedge clk);
    check(ident == 8'h02, "R9 second event", ident, 8'h02);
    thr_wr = 1;
    @(negedge clk); thr_wr = 0;
    check(ident == 8'h01, "R9 write clears", ident, 8'h01);
    wr_ier(8'h00);
    wr_ier(8'h02);
    #1;
    check(ident == 8'h02, "R9 enable re-arm", ident, 8'h02);

    // R4 R10: full priority ladder
    wr_ier(8'h0F);
    out2 = 1; line_err = 4'h2; rx_level = 1; modem_delta = 4'h4; #1;
    check(ident == 8'h06, "R4 line first", ident, 8'h06);
    check(irq == 1, "R10 irq", irq, 1);
    line_err = 0; #1;
    check(ident == 8'h04, "R4 rx second", ident, 8'h04);
    rx_level = 0; #1;
    check(ident == 8'h02, "R4 tx third", ident, 8'h02);
    @(negedge clk); iir_rd = 1;
    @(negedge clk); iir_rd = 0;
    check(ident == 8'h00, "R4 modem last", ident, 8'h00);
    out2 = 0; #1;
    check(irq == 0, "R10 out2 gate", irq, 0);
    modem_delta = 0; out2 = 1; #1;
    check(ident == 8'h01 && irq == 0, "R5 idle", ident, 8'h01);
    thr_empty = 0;

    // Random combinations, no timeout or tx events active
    for (int i = 0; i < 300; i++) begin
      logic [7:0] f, e, exp;
      f = 8'($urandom) & 8'hC1;
      e = 8'($urandom);
      wr_fcr(f);
      wr_ier(e);
      rx_level = 5'($urandom % 17);
      line_err = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      modem_delta = 4'($urandom);
      out2 = 1'($urandom);
      #1;
      exp = exp_ident(e[3:0], int'(rx_level), f[0], f[7:6], line_err, modem_delta, 0, 0);
      check(ident == exp, "R4 R2 random ident", ident, exp);
      check(irq == (!exp[0] && out2), "R10 random irq", irq, !exp[0] && out2);
      check(ier_q == {4'h0, e[3:0]}, "R1 random ier", ier_q, e[3:0]);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule